// File: doc/BRIEF.md
# Superframe Position Tracker

This block counts frames of a serial time-division bus to know where the transmit side is inside a multi-frame superframe. It runs on the bus bit clock. It acts only on cycles where the one-cycle frame pulse is high. At each such pulse the position count either moves forward by one, with wrap-around, or reloads to zero. The role input selects what may cause a reload.

In the line-termination role, software sets the superframe phase with a control bit. The bit is sampled once per frame. A change from 1 to 0, seen across two consecutive samples, makes the frame that starts at the second sample the first frame of a new superframe. The change therefore takes effect one frame after it was made.

In the network-termination role, the control bit has no effect. The transmit superframe instead follows the receive superframe boundary indication. In this role the block also drives an active-low boundary marker. The marker is low for one whole frame at the transmit superframe start, and only while receive superframe sync is reported.

Top module: `sf_tracker`

## Requirements
- R1: While reset is high, and after it is released until the first frame pulse, `sf_pos` is 0, `tx_sf_start` is 1 and `sf_marker_n` is 1.
- R2: With `nt_mode`=0 and no reload, each frame pulse advances `sf_pos` by one. It goes from SF_LEN-1 back to 0.
- R3: With `nt_mode`=0, a frame pulse where `sf_ctl_bit` samples 0 and the sample at the previous frame pulse was 1 loads `sf_pos` with 0.
- R4: With `nt_mode`=0, a 0-to-1 change or a steady level of `sf_ctl_bit` between frame pulses causes no reload, and the count advances as in R2.
- R5: With `nt_mode`=1, `sf_ctl_bit` has no effect on `sf_pos`, including at a 1-to-0 change.
- R6: With `nt_mode`=1, a frame pulse with `rx_sf_bound`=1 loads `sf_pos` with 0. A frame pulse with `rx_sf_bound`=0 advances it as in R2.
- R7: `tx_sf_start` is 1 exactly while `sf_pos` is 0.
- R8: `sf_marker_n` is updated at each frame pulse. It goes to 0 for that frame only when `nt_mode`=1, `rx_sf_sync`=1 and the new `sf_pos` is 0. In every other case it is 1.
- R9: Between frame pulses, `sf_pos` and `sf_marker_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle frame start strobe |
| nt_mode | input | 1 | 1 = network-termination role, 0 = line-termination role |
| sf_ctl_bit | input | 1 | Software superframe phase control bit |
| rx_sf_sync | input | 1 | Receive superframe sync achieved |
| rx_sf_bound | input | 1 | Current frame is a receive superframe boundary |
| sf_pos | output | $clog2(SF_LEN) | Frame position inside the superframe |
| tx_sf_start | output | 1 | High during the first frame of the transmit superframe |
| sf_marker_n | output | 1 | Active-low superframe boundary marker |

## Verification
The assertions check on every cycle that the outputs hold between pulses and that the count advances with wrap whenever no reload can occur. They also check that a receive boundary in the network role forces position zero, and that the marker never goes low without sync or away from position zero. Some behaviours depend on the control-bit sample from one frame earlier: the one-frame-late reload on a falling edge, the absence of a reload on a rising edge, and that the bit is ignored in the network role. Only the bench's scenarios can show these, so it compares each frame against its own model.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic {
        ROLE_LT = 1'b0,
        ROLE_NT = 1'b1
    } role_e;

    typedef struct packed {
        logic  tick;     // frame pulse this cycle
        logic  sw_fall;  // 1-to-0 seen on the control bit at this pulse
        role_e role;
        logic  rx_bnd;
        logic  rx_sync;
    } frame_ctl_t;

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned len);
        return (p + 1 >= len) ? 0 : p + 1;
    endfunction

    function automatic logic want_reload(frame_ctl_t c);
        return (c.role == ROLE_NT) ? c.rx_bnd : c.sw_fall;
    endfunction

endpackage

// File: rtl/sfc_ctl_sampler.sv
module sfc_ctl_sampler (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ctl_bit,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (tick) begin
            prev_q <= ctl_bit;
        end
    end

    assign fall = tick & prev_q & ~ctl_bit;
endmodule

// File: rtl/sfc_pos_counter.sv
module sfc_pos_counter
    import sfc_pkg::*;
#(
    parameter int unsigned SF_LEN = 8,
    localparam int unsigned CW = (SF_LEN > 1) ? $clog2(SF_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_ctl_t    ctl,
    output logic [CW-1:0] pos,
    output logic [CW-1:0] pos_nxt
);
    logic [CW-1:0] pos_q;

    always_comb begin
        if (want_reload(ctl)) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = CW'(wrap_inc(32'(pos_q), SF_LEN));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (ctl.tick) begin
            pos_q <= pos_nxt;
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/sfc_marker.sv
module sfc_marker
    import sfc_pkg::*;
#(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_ctl_t    ctl,
    input  logic [CW-1:0] pos_nxt,
    output logic          marker_n
);
    logic mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= 1'b1;
        end else if (ctl.tick) begin
            mark_q <= ~((ctl.role == ROLE_NT) && ctl.rx_sync && (pos_nxt == '0));
        end
    end

    assign marker_n = mark_q;
endmodule

// File: rtl/sf_tracker.sv
module sf_tracker
    import sfc_pkg::*;
#(
    parameter int unsigned SF_LEN = 8,
    localparam int unsigned CW = (SF_LEN > 1) ? $clog2(SF_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_pulse,
    input  logic          nt_mode,
    input  logic          sf_ctl_bit,
    input  logic          rx_sf_sync,
    input  logic          rx_sf_bound,
    output logic [CW-1:0] sf_pos,
    output logic          tx_sf_start,
    output logic          sf_marker_n
);
    frame_ctl_t    ctl;
    logic          sw_fall;
    logic [CW-1:0] pos_nxt;

    sfc_ctl_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .tick    (frame_pulse),
        .ctl_bit (sf_ctl_bit),
        .fall    (sw_fall)
    );

    always_comb begin
        ctl.tick    = frame_pulse;
        ctl.sw_fall = sw_fall;
        ctl.role    = nt_mode ? ROLE_NT : ROLE_LT;
        ctl.rx_bnd  = rx_sf_bound;
        ctl.rx_sync = rx_sf_sync;
    end

    sfc_pos_counter #(.SF_LEN(SF_LEN)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .pos     (sf_pos),
        .pos_nxt (pos_nxt)
    );

    sfc_marker #(.CW(CW)) u_mark (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .pos_nxt  (pos_nxt),
        .marker_n (sf_marker_n)
    );

    assign tx_sf_start = (sf_pos == '0);
endmodule

// File: rtl/sf_tracker_chk.sv
module sf_tracker_chk #(
    parameter int unsigned SF_LEN = 8,
    localparam int unsigned CW = (SF_LEN > 1) ? $clog2(SF_LEN) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_pulse,
    input logic          nt_mode,
    input logic          sf_ctl_bit,
    input logic          rx_sf_sync,
    input logic          rx_sf_bound,
    input logic [CW-1:0] sf_pos,
    input logic          tx_sf_start,
    input logic          sf_marker_n
);
    function automatic logic [CW-1:0] step(logic [CW-1:0] p);
        return (32'(p) == SF_LEN - 1) ? '0 : p + 1'b1;
    endfunction

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_pulse |=> ($stable(sf_pos) && $stable(sf_marker_n)));

    // R2: with the control bit sampled high no falling edge is possible
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && !nt_mode && sf_ctl_bit) |=> (sf_pos == step($past(sf_pos))));

    assert_nt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && nt_mode && rx_sf_bound) |=> (sf_pos == '0));

    // R5: control bit cannot reload in the network role
    assert_nt_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && nt_mode && !rx_sf_bound) |=> (sf_pos == step($past(sf_pos))));

    assert_nosync_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && !rx_sf_sync) |=> sf_marker_n);

    assert_mark_pos_R8: assert property (@(posedge clk) disable iff (rst)
        !sf_marker_n |-> tx_sf_start);

    assert_start_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && nt_mode && rx_sf_bound) |=> tx_sf_start);
endmodule

bind sf_tracker sf_tracker_chk #(.SF_LEN(SF_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_pulse (frame_pulse),
    .nt_mode     (nt_mode),
    .sf_ctl_bit  (sf_ctl_bit),
    .rx_sf_sync  (rx_sf_sync),
    .rx_sf_bound (rx_sf_bound),
    .sf_pos      (sf_pos),
    .tx_sf_start (tx_sf_start),
    .sf_marker_n (sf_marker_n)
);

// File: tb/tb_sf_tracker.sv
`timescale 1ns/1ps
module tb_sf_tracker;
    localparam int unsigned SF_LEN = 8;
    localparam int unsigned CW = $clog2(SF_LEN);
    localparam int FRAME_CYC = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_pulse = 1'b0;
    logic          nt_mode = 1'b0;
    logic          sf_ctl_bit = 1'b0;
    logic          rx_sf_sync = 1'b0;
    logic          rx_sf_bound = 1'b0;
    logic [CW-1:0] sf_pos;
    logic          tx_sf_start;
    logic          sf_marker_n;

    int checks = 0;
    int errors = 0;
    int unsigned m_pos = 0;
    logic m_prev = 1'b0;
    logic m_mark = 1'b1;
    string m_tag = "R2";
    bit done = 1'b0;

    always #5 clk = ~clk;

    sf_tracker #(.SF_LEN(SF_LEN)) dut (
        .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .nt_mode(nt_mode),
        .sf_ctl_bit(sf_ctl_bit), .rx_sf_sync(rx_sf_sync), .rx_sf_bound(rx_sf_bound),
        .sf_pos(sf_pos), .tx_sf_start(tx_sf_start), .sf_marker_n(sf_marker_n)
    );

    function automatic int unsigned nxt(int unsigned p);
        return (p + 1 >= SF_LEN) ? 0 : p + 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_pulse(logic sw, logic nt, logic sync, logic bnd);
        logic fall;
        fall = m_prev && !sw;
        m_prev = sw;
        if (nt) begin
            m_tag = bnd ? "R6" : "R5";
            m_pos = bnd ? 0 : nxt(m_pos);
        end else begin
            m_tag = fall ? "R3" : "R2";
            m_pos = fall ? 0 : nxt(m_pos);
        end
        m_mark = !(nt && sync && m_pos == 0);
    endtask

    task automatic frame(logic sw, logic nt, logic sync, logic bnd, string tag = "");
        @(negedge clk);
        sf_ctl_bit = sw; nt_mode = nt; rx_sf_sync = sync; rx_sf_bound = bnd;
        frame_pulse = 1'b1;
        @(posedge clk);
        model_pulse(sw, nt, sync, bnd);
        @(negedge clk);
        frame_pulse = 1'b0;
        rx_sf_bound = $urandom_range(0, 1);
        rx_sf_sync = $urandom_range(0, 1);
        sf_ctl_bit = $urandom_range(0, 1);
        check((tag != "") ? tag : m_tag, int'(sf_pos), int'(m_pos));
        check("R7", int'(tx_sf_start), int'(m_pos == 0));
        check("R8", int'(sf_marker_n), int'(m_mark));
        repeat (FRAME_CYC - 2) @(negedge clk);
        check("R9", int'(sf_pos), int'(m_pos));
        check("R9", int'(sf_marker_n), int'(m_mark));
        sf_ctl_bit = sw;
    endtask

    initial begin
        fork
            begin
                void'($urandom(32'h5F1A));
                repeat (3) @(negedge clk);
                check("R1", int'(sf_pos), 0);
                check("R1", int'(sf_marker_n), 1);
                rst = 1'b0;
                repeat (3) @(negedge clk);
                check("R1", int'(sf_pos), 0);
                check("R1", int'(tx_sf_start), 1);
                check("R1", int'(sf_marker_n), 1);
                // LT wrap through a full superframe
                for (int i = 0; i < SF_LEN + 2; i++) frame(1'b0, 1'b0, 1'b1, 1'b0);
                // rising edge then steady high: no reload
                frame(1'b1, 1'b0, 1'b1, 1'b0, "R4");
                frame(1'b1, 1'b0, 1'b1, 1'b0, "R4");
                // falling edge: reload, one frame after the change
                frame(1'b0, 1'b0, 1'b1, 1'b0, "R3");
                frame(1'b0, 1'b0, 1'b1, 1'b0, "R2");
                // NT: falling edge ignored
                frame(1'b1, 1'b1, 1'b1, 1'b0, "R5");
                frame(1'b0, 1'b1, 1'b1, 1'b0, "R5");
                // NT boundary with sync: marker low one frame
                frame(1'b0, 1'b1, 1'b1, 1'b1, "R6");
                frame(1'b0, 1'b1, 1'b1, 1'b0, "R6");
                // NT boundary without sync: marker stays high
                frame(1'b0, 1'b1, 1'b0, 1'b1, "R6");
                // constrained random
                for (int i = 0; i < 400; i++) begin
                    logic nt, sw, sync, bnd;
                    nt   = ((i / 50) % 2) == 1;
                    sw   = ($urandom_range(0, 3) == 0) ? ~m_prev : m_prev;
                    sync = $urandom_range(0, 7) != 0;
                    bnd  = (m_pos == SF_LEN - 1) ? ($urandom_range(0, 7) != 0)
                                                 : ($urandom_range(0, 15) == 0);
                    frame(sw, nt, sync, bnd);
                end
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule